// File: doc/BRIEF.md
# Dual-Port Bank Arbiter for a Multibanked Cache

This block sits in front of a data cache made of single-ported banks and lets two load ports reach the cache in the same cycle. Each port presents a request with a byte address, a size code and a valid bit. The block maps each address to a bank by interleaving consecutive cache lines across the banks. It decides which requests can be served this cycle without two pieces landing on the same bank, and hands each bank at most one piece to work on in the next cycle.

A request whose bytes run past the end of its line is cut into two aligned pieces: the tail of the current line and the head of the next. Because neighbouring lines live in neighbouring banks, the two pieces always go to different banks and are issued in the same cycle. The split therefore costs no extra latency, but it uses two bank slots and can push the other port out for that cycle. Port 0 always wins. When port 1 loses, it sees a stall in the same cycle and must hold its request for a retry on the next cycle.

Every issued piece carries its line address, byte offset, byte length, the port it came from, and two flags that mark split pieces and tell the first piece from the second, so the load data can be merged downstream.

Top module: `dport_bank_arb`

## Requirements
- R1: The bank of a request is address bits [7:6], and its line address is address bits [31:6]. An accepted piece appears on that bank's outputs one clock edge after acceptance.
- R2: A request with offset (address bits [5:0]) plus 2^size bytes no greater than 64 gives one piece. That piece carries offset = address[5:0] and length = 2^size bytes (size 0,1,2,3 mean 1,2,4,8 bytes), with split flag 0 and second-half flag 0.
- R3: A request with offset plus 2^size greater than 64 gives two pieces issued together. The first goes on bank b with the request's offset, length 64 minus offset, split 1 and second-half 0. The second goes on bank (b+1) mod 4 with line address plus one, offset 0, the remaining length, split 1 and second-half 1.
- R4: Port 0 is never stalled: its accept equals its valid and its stall is 0.
- R5: When both ports need the same bank, port 1 is stalled, and that bank carries the piece from port 0.
- R6: When port 0 is split, port 1 is stalled if any bank it needs matches either half, and accepted otherwise.
- R7: A split request on port 1 is accepted only if neither of its two banks is used by port 0.
- R8: The number of valid bank outputs in a cycle equals the number of pieces accepted in the cycle before.
- R9: Accept and stall respond in the same cycle as the request, stall equals valid and not accept, and a port without valid gets neither and issues nothing.
- R10: While reset is low, and on the first edge after it, every bank output is invalid.
- R11: The port tag of each issued piece is 0 for port 0 and 1 for port 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_vld | input | 2 | Request valid, one bit per port |
| req_addr | input | 2x32 | Byte address per port |
| req_size | input | 2x2 | Size code per port, 2^size bytes |
| port_acc | output | 2 | Request taken this cycle, per port |
| port_stall | output | 2 | Request refused this cycle and must be held, per port |
| bank_vld | output | 4 | A piece is issued to the bank |
| bank_line | output | 4x26 | Line address of the issued piece |
| bank_off | output | 4x6 | Byte offset of the piece within its line |
| bank_len | output | 4x4 | Byte length of the piece |
| bank_port | output | 4 | Port that the piece came from |
| bank_split | output | 4 | Piece is one half of a split request |
| bank_half | output | 4 | Piece is the second half of a split request |

## Verification
Accept and stall are combinational, so they are due in the cycle the request is presented. The bench drives requests on the falling edge and samples these two outputs a nanosecond later. Bank outputs are registered once, so they are due after the next rising edge. The bench reads them at the following falling edge, before the next request is applied, and compares them against a model of the expected pieces computed from the requirements.

// File: rtl/dpba_pkg.sv
// Shared types for the dual-port bank arbiter.
// Assumes nothing beyond the piece kinds listed here.
package dpba_pkg;

    // Kind of an issued piece: a whole request, or one half of a split one.
    typedef enum logic [1:0] {
        PIECE_WHOLE  = 2'd0,
        PIECE_FIRST  = 2'd1,
        PIECE_SECOND = 2'd2
    } piece_kind_e;

endpackage

// File: rtl/dpba_decode.sv
// Address decode for one port: bank, line, offset, piece lengths, and
// whether the request runs past its line end.
// Assumes a power-of-two bank count and that the largest access fits
// within one line.
module dpba_decode #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 6,
    parameter int BANK_W = 2,
    parameter int SIZE_W = 2,
    parameter int LEN_W  = 4,
    localparam int LINE_W    = ADDR_W - OFF_W,
    localparam int NUM_BANKS = 1 << BANK_W
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic [SIZE_W-1:0]    size,
    output logic [BANK_W-1:0]    bank_a,
    output logic [BANK_W-1:0]    bank_b,
    output logic [LINE_W-1:0]    line_a,
    output logic [LINE_W-1:0]    line_b,
    output logic [OFF_W-1:0]     off_a,
    output logic [LEN_W-1:0]     len_a,
    output logic [LEN_W-1:0]     len_b,
    output logic                 crosses,
    output logic [NUM_BANKS-1:0] mask
);

    localparam int SUM_W = OFF_W + 1;

    logic [SUM_W-1:0] bytes_w;
    logic [SUM_W-1:0] end_w;
    logic [SUM_W-1:0] head_w;
    logic [SUM_W-1:0] line_bytes_w;

    // Split the address into line and offset; next line is one above.
    always_comb begin
        line_a = addr[ADDR_W-1:OFF_W];
        line_b = line_a + LINE_W'(1);
        off_a  = addr[OFF_W-1:0];
        bank_a = line_a[BANK_W-1:0];
        bank_b = line_b[BANK_W-1:0];
    end

    // Work out the end byte and the lengths of the two possible pieces.
    always_comb begin
        line_bytes_w = SUM_W'(1) << OFF_W;
        bytes_w      = SUM_W'(1) << size;
        end_w        = {1'b0, off_a} + bytes_w;
        head_w       = line_bytes_w - {1'b0, off_a};
        crosses      = end_w > line_bytes_w;
        len_a        = crosses ? LEN_W'(head_w) : LEN_W'(bytes_w);
        len_b        = crosses ? LEN_W'(end_w[OFF_W-1:0]) : '0;
    end

    // One mask bit per bank that this request would occupy.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_mask
        assign mask[b] = (bank_a == BANK_W'(b)) || (crosses && (bank_b == BANK_W'(b)));
    end

endmodule

// File: rtl/dpba_grant.sv
// Fixed-priority grant between the two ports. Port 0 always goes;
// port 1 goes only if its bank set does not overlap port 0's.
// Assumes the requester holds a stalled request until accepted.
module dpba_grant #(
    parameter int NUM_BANKS = 4
) (
    input  logic [1:0]           vld,
    input  logic [NUM_BANKS-1:0] mask0,
    input  logic [NUM_BANKS-1:0] mask1,
    output logic [1:0]           acc,
    output logic [1:0]           stall
);

    logic overlap;

    // Decide acceptance and stall for both ports in the same cycle.
    always_comb begin
        overlap = vld[0] && (|(mask0 & mask1));
        acc[0]  = vld[0];
        acc[1]  = vld[1] && !overlap;
        stall   = vld & ~acc;
    end

endmodule

// File: rtl/dpba_issue.sv
// Per-bank issue registers. Each bank picks the piece that falls on it,
// giving port 0 priority, and registers it for one cycle.
// Assumes the grant stage never accepts two pieces for one bank.
module dpba_issue
    import dpba_pkg::*;
#(
    parameter int LINE_W = 26,
    parameter int OFF_W  = 6,
    parameter int BANK_W = 2,
    parameter int LEN_W  = 4,
    localparam int NUM_BANKS = 1 << BANK_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [1:0]                   acc,
    input  logic [1:0][BANK_W-1:0]       bank_a,
    input  logic [1:0][BANK_W-1:0]       bank_b,
    input  logic [1:0][LINE_W-1:0]       line_a,
    input  logic [1:0][LINE_W-1:0]       line_b,
    input  logic [1:0][OFF_W-1:0]        off_a,
    input  logic [1:0][LEN_W-1:0]        len_a,
    input  logic [1:0][LEN_W-1:0]        len_b,
    input  logic [1:0]                   crosses,
    output logic [NUM_BANKS-1:0]         bank_vld,
    output logic [NUM_BANKS-1:0][LINE_W-1:0] bank_line,
    output logic [NUM_BANKS-1:0][OFF_W-1:0]  bank_off,
    output logic [NUM_BANKS-1:0][LEN_W-1:0]  bank_len,
    output logic [NUM_BANKS-1:0]         bank_port,
    output logic [NUM_BANKS-1:0]         bank_split,
    output logic [NUM_BANKS-1:0]         bank_half
);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic              nxt_vld;
        logic [LINE_W-1:0] nxt_line;
        logic [OFF_W-1:0]  nxt_off;
        logic [LEN_W-1:0]  nxt_len;
        logic              nxt_port;
        piece_kind_e       nxt_kind;
        piece_kind_e       cur_kind;

        // Select this bank's piece; port 0 is visited last so it wins.
        always_comb begin
            nxt_vld  = 1'b0;
            nxt_line = '0;
            nxt_off  = '0;
            nxt_len  = '0;
            nxt_port = 1'b0;
            nxt_kind = PIECE_WHOLE;
            for (int p = 1; p >= 0; p--) begin
                if (acc[p] && bank_a[p] == BANK_W'(b)) begin
                    nxt_vld  = 1'b1;
                    nxt_line = line_a[p];
                    nxt_off  = off_a[p];
                    nxt_len  = len_a[p];
                    nxt_port = (p == 1);
                    nxt_kind = crosses[p] ? PIECE_FIRST : PIECE_WHOLE;
                end else if (acc[p] && crosses[p] && bank_b[p] == BANK_W'(b)) begin
                    nxt_vld  = 1'b1;
                    nxt_line = line_b[p];
                    nxt_off  = '0;
                    nxt_len  = len_b[p];
                    nxt_port = (p == 1);
                    nxt_kind = PIECE_SECOND;
                end
            end
        end

        // Register the chosen piece for the bank.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank_vld[b]  <= 1'b0;
                bank_line[b] <= '0;
                bank_off[b]  <= '0;
                bank_len[b]  <= '0;
                bank_port[b] <= 1'b0;
                cur_kind     <= PIECE_WHOLE;
            end else begin
                bank_vld[b]  <= nxt_vld;
                bank_line[b] <= nxt_line;
                bank_off[b]  <= nxt_off;
                bank_len[b]  <= nxt_len;
                bank_port[b] <= nxt_port;
                cur_kind     <= nxt_kind;
            end
        end

        // Expose the piece kind as the two merge flags.
        assign bank_split[b] = (cur_kind != PIECE_WHOLE);
        assign bank_half[b]  = (cur_kind == PIECE_SECOND);
    end

endmodule

// File: rtl/dport_bank_arb.sv
// Top of the dual-port bank arbiter: decodes both ports, grants with
// port 0 priority, and registers one piece per bank.
// Assumes a stalled port holds its request until it is accepted.
module dport_bank_arb #(
    parameter int ADDR_W    = 32,
    parameter int OFF_W     = 6,
    parameter int NUM_BANKS = 4,
    parameter int SIZE_W    = 2,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int LINE_W   = ADDR_W - OFF_W,
    localparam int MAX_LOG  = (1 << SIZE_W) - 1,
    localparam int LEN_W    = MAX_LOG + 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [1:0]                       req_vld,
    input  logic [1:0][ADDR_W-1:0]           req_addr,
    input  logic [1:0][SIZE_W-1:0]           req_size,
    output logic [1:0]                       port_acc,
    output logic [1:0]                       port_stall,
    output logic [NUM_BANKS-1:0]             bank_vld,
    output logic [NUM_BANKS-1:0][LINE_W-1:0] bank_line,
    output logic [NUM_BANKS-1:0][OFF_W-1:0]  bank_off,
    output logic [NUM_BANKS-1:0][LEN_W-1:0]  bank_len,
    output logic [NUM_BANKS-1:0]             bank_port,
    output logic [NUM_BANKS-1:0]             bank_split,
    output logic [NUM_BANKS-1:0]             bank_half
);

    logic [1:0][BANK_W-1:0]    dec_bank_a;
    logic [1:0][BANK_W-1:0]    dec_bank_b;
    logic [1:0][LINE_W-1:0]    dec_line_a;
    logic [1:0][LINE_W-1:0]    dec_line_b;
    logic [1:0][OFF_W-1:0]     dec_off;
    logic [1:0][LEN_W-1:0]     dec_len_a;
    logic [1:0][LEN_W-1:0]     dec_len_b;
    logic [1:0]                dec_cross;
    logic [1:0][NUM_BANKS-1:0] dec_mask;

    // One decoder per port.
    for (genvar p = 0; p < 2; p++) begin : g_port
        dpba_decode #(
            .ADDR_W (ADDR_W),
            .OFF_W  (OFF_W),
            .BANK_W (BANK_W),
            .SIZE_W (SIZE_W),
            .LEN_W  (LEN_W)
        ) decode_i (
            .addr    (req_addr[p]),
            .size    (req_size[p]),
            .bank_a  (dec_bank_a[p]),
            .bank_b  (dec_bank_b[p]),
            .line_a  (dec_line_a[p]),
            .line_b  (dec_line_b[p]),
            .off_a   (dec_off[p]),
            .len_a   (dec_len_a[p]),
            .len_b   (dec_len_b[p]),
            .crosses (dec_cross[p]),
            .mask    (dec_mask[p])
        );
    end

    dpba_grant #(
        .NUM_BANKS (NUM_BANKS)
    ) grant_i (
        .vld   (req_vld),
        .mask0 (dec_mask[0]),
        .mask1 (dec_mask[1]),
        .acc   (port_acc),
        .stall (port_stall)
    );

    dpba_issue #(
        .LINE_W (LINE_W),
        .OFF_W  (OFF_W),
        .BANK_W (BANK_W),
        .LEN_W  (LEN_W)
    ) issue_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc        (port_acc),
        .bank_a     (dec_bank_a),
        .bank_b     (dec_bank_b),
        .line_a     (dec_line_a),
        .line_b     (dec_line_b),
        .off_a      (dec_off),
        .len_a      (dec_len_a),
        .len_b      (dec_len_b),
        .crosses    (dec_cross),
        .bank_vld   (bank_vld),
        .bank_line  (bank_line),
        .bank_off   (bank_off),
        .bank_len   (bank_len),
        .bank_port  (bank_port),
        .bank_split (bank_split),
        .bank_half  (bank_half)
    );

endmodule

// File: rtl/dport_bank_arb_chk.sv
// Assertion checker for the dual-port bank arbiter, bound to the top.
// Assumes the top's default geometry is passed in through parameters.
module dport_bank_arb_chk #(
    parameter int ADDR_W    = 32,
    parameter int OFF_W     = 6,
    parameter int NUM_BANKS = 4,
    parameter int SIZE_W    = 2,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int SUM_W    = OFF_W + 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [1:0]             req_vld,
    input logic [1:0][ADDR_W-1:0] req_addr,
    input logic [1:0][SIZE_W-1:0] req_size,
    input logic [1:0]             port_acc,
    input logic [1:0]             port_stall,
    input logic [NUM_BANKS-1:0]   bank_vld,
    input logic [NUM_BANKS-1:0]   bank_port
);

    function automatic logic runs_over(input logic [ADDR_W-1:0] a, input logic [SIZE_W-1:0] s);
        logic [SUM_W-1:0] e;
        e = {1'b0, a[OFF_W-1:0]} + (SUM_W'(1) << s);
        return e > (SUM_W'(1) << OFF_W);
    endfunction

    logic [2:0] piece_cnt;

    // Pieces accepted this cycle, as seen from the ports.
    always_comb begin
        piece_cnt = 3'd0;
        for (int p = 0; p < 2; p++) begin
            if (port_acc[p]) begin
                piece_cnt = piece_cnt + (runs_over(req_addr[p], req_size[p]) ? 3'd2 : 3'd1);
            end
        end
    end

    AST_P0_NEVER_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld[0] |-> (port_acc[0] && !port_stall[0])); // R4

    AST_STALL_ONLY_WHEN_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        port_stall[1] |-> (req_vld[1] && !port_acc[1])); // R9

    AST_SAME_BANK_STALLS_P1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld[0] && req_vld[1] &&
         req_addr[0][OFF_W +: BANK_W] == req_addr[1][OFF_W +: BANK_W]) |-> port_stall[1]); // R5

    AST_P0_LANDS_ON_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld[0] |=> (bank_vld[$past(req_addr[0][OFF_W +: BANK_W])] &&
                        !bank_port[$past(req_addr[0][OFF_W +: BANK_W])])); // R1

    AST_P1_LANDS_ON_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (port_acc[1] && !req_vld[0]) |=> (bank_vld[$past(req_addr[1][OFF_W +: BANK_W])] &&
                                          bank_port[$past(req_addr[1][OFF_W +: BANK_W])])); // R11

    AST_IDLE_ISSUES_NOTHING: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld == 2'b00) |=> (bank_vld == '0)); // R9

    AST_PIECE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(bank_vld) == int'($past(piece_cnt)))); // R8

    AST_SPLIT_TAKES_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld[0] && runs_over(req_addr[0], req_size[0])) |=> ($countones(bank_vld) >= 2)); // R3

endmodule

bind dport_bank_arb dport_bank_arb_chk #(
    .ADDR_W    (ADDR_W),
    .OFF_W     (OFF_W),
    .NUM_BANKS (NUM_BANKS),
    .SIZE_W    (SIZE_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_vld    (req_vld),
    .req_addr   (req_addr),
    .req_size   (req_size),
    .port_acc   (port_acc),
    .port_stall (port_stall),
    .bank_vld   (bank_vld),
    .bank_port  (bank_port)
);

// File: tb/dport_bank_arb_tb_top.sv
// Testbench for the dual-port bank arbiter: a vector table walked by one
// loop, then directed reset tests.
module dport_bank_arb_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NB = 4;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [1:0]           req_vld = '0;
    logic [1:0][31:0]     req_addr = '0;
    logic [1:0][1:0]      req_size = '0;
    logic [1:0]           port_acc;
    logic [1:0]           port_stall;
    logic [NB-1:0]        bank_vld;
    logic [NB-1:0][25:0]  bank_line;
    logic [NB-1:0][5:0]   bank_off;
    logic [NB-1:0][3:0]   bank_len;
    logic [NB-1:0]        bank_port;
    logic [NB-1:0]        bank_split;
    logic [NB-1:0]        bank_half;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dport_bank_arb dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_vld    (req_vld),
        .req_addr   (req_addr),
        .req_size   (req_size),
        .port_acc   (port_acc),
        .port_stall (port_stall),
        .bank_vld   (bank_vld),
        .bank_line  (bank_line),
        .bank_off   (bank_off),
        .bank_len   (bank_len),
        .bank_port  (bank_port),
        .bank_split (bank_split),
        .bank_half  (bank_half)
    );

    typedef struct packed {
        logic        v0;
        logic [31:0] a0;
        logic [1:0]  s0;
        logic        v1;
        logic [31:0] a1;
        logic [1:0]  s1;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 32'h0000_0000, 2'd2, 1'b1, 32'h0000_0040, 2'd3},
        '{1'b1, 32'h0000_0100, 2'd2, 1'b1, 32'h0000_0000, 2'd0},
        '{1'b1, 32'h0000_003C, 2'd3, 1'b1, 32'h0000_0080, 2'd2},
        '{1'b1, 32'h0000_003C, 2'd3, 1'b1, 32'h0000_0040, 2'd1},
        '{1'b1, 32'h0000_00FE, 2'd1, 1'b1, 32'h0000_00FF, 2'd1},
        '{1'b1, 32'h0000_0000, 2'd0, 1'b1, 32'h0000_00BD, 2'd2},
        '{1'b1, 32'h0000_00C0, 2'd0, 1'b1, 32'h0000_00BD, 2'd2},
        '{1'b0, 32'h0000_0000, 2'd0, 1'b1, 32'h0000_0000, 2'd3},
        '{1'b0, 32'h0000_0040, 2'd0, 1'b0, 32'h0000_0080, 2'd0},
        '{1'b1, 32'hFFFF_FFFE, 2'd2, 1'b0, 32'h0000_0000, 2'd0},
        '{1'b1, 32'h0000_01FC, 2'd2, 1'b1, 32'h0000_023F, 2'd0}
    };

    function automatic string row_tag(input int i);
        case (i)
            0:       return "R1 R2 R11";
            1:       return "R5";
            2:       return "R3 R6";
            3:       return "R6";
            4:       return "R5 R2";
            5:       return "R7 R3";
            6:       return "R7";
            7:       return "R9 R11";
            8:       return "R9 R8";
            9:       return "R3 R4";
            default: return "R2 R8";
        endcase
    endfunction

    logic [NB-1:0]       exp_vld;
    logic [NB-1:0][38:0] exp_piece;
    logic [1:0]          exp_acc;

    // Expected pieces from the requirements: bank = addr[7:6], 64-byte lines.
    task automatic model(input vec_t v);
        logic [NB-1:0] m [2];
        logic          vv [2];
        logic [31:0]   aa [2];
        logic [1:0]    ss [2];
        vv[0] = v.v0; aa[0] = v.a0; ss[0] = v.s0;
        vv[1] = v.v1; aa[1] = v.a1; ss[1] = v.s1;
        exp_vld = '0;
        exp_piece = '0;
        for (int p = 0; p < 2; p++) begin
            int off = int'(aa[p][5:0]);
            int nby = 1 << ss[p];
            int bk = int'(aa[p][7:6]);
            m[p] = '0;
            m[p][bk] = 1'b1;
            if (off + nby > 64) m[p][(bk + 1) % NB] = 1'b1;
        end
        exp_acc[0] = vv[0];
        exp_acc[1] = vv[1] && !(vv[0] && ((m[0] & m[1]) != '0));
        for (int p = 0; p < 2; p++) begin
            if (exp_acc[p]) begin
                int off = int'(aa[p][5:0]);
                int nby = 1 << ss[p];
                int bk = int'(aa[p][7:6]);
                logic [25:0] ln = aa[p][31:6];
                if (off + nby > 64) begin
                    exp_vld[bk] = 1'b1;
                    exp_piece[bk] = {ln, 6'(off), 4'(64 - off), 1'(p), 1'b1, 1'b0};
                    exp_vld[(bk + 1) % NB] = 1'b1;
                    exp_piece[(bk + 1) % NB] = {26'(ln + 26'd1), 6'd0, 4'(off + nby - 64), 1'(p), 1'b1, 1'b1};
                end else begin
                    exp_vld[bk] = 1'b1;
                    exp_piece[bk] = {ln, 6'(off), 4'(nby), 1'(p), 1'b0, 1'b0};
                end
            end
        end
    endtask

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_banks(input string tag);
        check(bank_vld == exp_vld, tag, "bank_vld", 64'(bank_vld), 64'(exp_vld));
        for (int b = 0; b < NB; b++) begin
            if (exp_vld[b] && bank_vld[b]) begin
                logic [38:0] act;
                act = {bank_line[b], bank_off[b], bank_len[b], bank_port[b], bank_split[b], bank_half[b]};
                check(act == exp_piece[b], tag, $sformatf("bank %0d piece", b), 64'(act), 64'(exp_piece[b]));
            end
        end
    endtask

    task automatic drive(input vec_t v);
        req_vld[0] = v.v0; req_addr[0] = v.a0; req_size[0] = v.s0;
        req_vld[1] = v.v1; req_addr[1] = v.a1; req_size[1] = v.s1;
    endtask

    bit done = 1'b0;

    initial begin
        // R10: outputs stay invalid through reset even with live requests.
        drive(VECS[0]);
        repeat (3) @(negedge clk);
        check(bank_vld == '0, "R10", "bank_vld in reset", 64'(bank_vld), 64'd0);
        rst_n = 1'b1;
        req_vld = '0;
        @(negedge clk);
        check(bank_vld == '0, "R10", "bank_vld first edge after reset", 64'(bank_vld), 64'd0);

        // Table walk: accept/stall checked in-cycle, pieces one edge later.
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            model(VECS[i]);
            #1;
            check(port_acc == exp_acc, row_tag(i), "port_acc", 64'(port_acc), 64'(exp_acc));
            check(port_stall == ({VECS[i].v1, VECS[i].v0} & ~exp_acc), row_tag(i) == "R5" ? "R5 R9" : "R9",
                  "port_stall", 64'(port_stall), 64'({VECS[i].v1, VECS[i].v0} & ~exp_acc));
            check(!port_stall[0], "R4", "port 0 stall", 64'(port_stall[0]), 64'd0);
            @(negedge clk);
            check_banks(row_tag(i));
        end

        // R5 retry: port 1 held after a stall is taken once port 0 moves away.
        drive(VECS[1]);
        model(VECS[1]);
        @(negedge clk);
        drive('{1'b1, 32'h0000_0040, 2'd2, 1'b1, 32'h0000_0000, 2'd0});
        model('{1'b1, 32'h0000_0040, 2'd2, 1'b1, 32'h0000_0000, 2'd0});
        #1;
        check(port_acc == 2'b11, "R5", "held request retried", 64'(port_acc), 64'd3);
        @(negedge clk);
        check_banks("R5 R11");

        // R10: reset in mid-run clears every bank output.
        drive(VECS[0]);
        rst_n = 1'b0;
        @(negedge clk);
        check(bank_vld == '0, "R10", "bank_vld after mid-run reset", 64'(bank_vld), 64'd0);
        rst_n = 1'b1;
        req_vld = '0;
        @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule